// File: doc/BRIEF.md
# Indexed Calendar Clock Register File

This block presents a calendar clock as a small register file behind two byte-wide I/O offsets. Software first writes a register number to the index port. Each later read of the data port returns the register that the stored number selects, and the number stays in place until the index port is written again. The calendar fields are fixed at elaboration from a preset time: seconds, minutes, hours, weekday, day of month, zero-based month and years since 1900.

Three status and control registers return fixed patterns. The one exception is the status register, which carries an update-in-progress flag. The flag starts at one and inverts after every read of that register. A free-running divider makes a one-cycle interrupt pulse at 1024 Hz, with the period given as a count of system clock cycles.

A register number with nothing behind it returns 0xFF and raises the error output. A write to the data port does the same, because the data port is read-only.

Top module: `rtc_regfile`

## Requirements
- R1: A write to offset 0x70 stores bus_wdata as the register number. Every later data-port read at offset 0x71 uses that number until 0x70 is written again.
- R2: Data-port reads return the preset calendar values as binary bytes at these register numbers: seconds 0, minutes 2, hours 4, weekday 6, day of month 7.
- R3: Register number 8 returns the preset zero-based month plus one, which lies in 1 to 12.
- R4: Register number 9 returns the preset years since 1900 minus 52, truncated to 8 bits.
- R5: Register number 10 returns the update-in-progress flag in bit 7 and 0x26 in bits 6:0. The flag is 1 after reset and inverts after each read of register 10.
- R6: Register number 11 always returns 0x46.
- R7: Register number 12 always returns 0x00.
- R8: A data-port read of any other register number (1, 3, 5, 13 to 255) returns 0xFF and sets bus_err for exactly one cycle.
- R9: A write to the data port sets bus_err for one cycle. It leaves bus_rdata, the stored register number and the update-in-progress flag unchanged.
- R10: After reset, bus_rdata is 0x00 and bus_err and tick_irq are 0. A data-port read updates bus_rdata in the cycle after the strobe, and the value holds until the next data-port read. bus_err is 0 for reads of mapped registers.
- R11: tick_irq is a one-cycle pulse every TICK_CYCLES clock cycles. The first pulse comes TICK_CYCLES cycles after reset is released.
- R12: Reads or writes at any offset other than 0x70 and 0x71 have no effect: bus_err stays 0 and bus_rdata and the stored register number are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | I/O offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| bus_err | output | 1 | One-cycle error flag for a bad access |
| tick_irq | output | 1 | 1024 Hz one-cycle interrupt pulse |

## Verification
The assertions assume that a read strobe and a write strobe are never high in the same cycle. They also assume that TICK_CYCLES is at least two, so that successive interrupt pulses cannot merge. The bench's access tasks raise exactly one strobe per access and hold it for a single cycle, with idle cycles between accesses. The two back-to-back status reads follow the same one-strobe rule and drive the flag-alternation property. The divider is run at a short period so that many pulses land inside the full sweep of all 256 register numbers.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;
    localparam logic [7:0] IDX_SEC   = 8'd0;
    localparam logic [7:0] IDX_MIN   = 8'd2;
    localparam logic [7:0] IDX_HOUR  = 8'd4;
    localparam logic [7:0] IDX_WDAY  = 8'd6;
    localparam logic [7:0] IDX_MDAY  = 8'd7;
    localparam logic [7:0] IDX_MON   = 8'd8;
    localparam logic [7:0] IDX_YEAR  = 8'd9;
    localparam logic [7:0] IDX_STATA = 8'd10;
    localparam logic [7:0] IDX_CTLB  = 8'd11;
    localparam logic [7:0] IDX_CTLC  = 8'd12;

    localparam logic [6:0] STATA_LOW = 7'h26;
    localparam logic [7:0] CTLB_VAL  = 8'h46;
    localparam logic [7:0] CTLC_VAL  = 8'h00;
    localparam logic [7:0] BAD_VAL   = 8'hFF;
    localparam int         YEAR_BIAS = 52;

    typedef struct packed {
        logic [7:0] index;
        logic       uip;
        logic [7:0] rdata;
        logic       err;
    } port_state_t;
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int TICK_CYCLES = 97656
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } div_t;

    div_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        d_d.tick = 1'b0;
        if (d_q.cnt == LAST) begin
            d_d.cnt  = '0;
            d_d.tick = 1'b1;
        end else begin
            d_d.cnt = d_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign tick = d_q.tick;
endmodule

// File: rtl/rtc_reg_mux.sv
module rtc_reg_mux
    import rtc_regs_pkg::*;
#(
    parameter int SEC_INIT   = 0,
    parameter int MIN_INIT   = 0,
    parameter int HOUR_INIT  = 0,
    parameter int WDAY_INIT  = 0,
    parameter int MDAY_INIT  = 1,
    parameter int MON0_INIT  = 0,
    parameter int YEAR_SINCE_1900 = 106
) (
    input  logic [7:0] index,
    input  logic       uip,
    output logic [7:0] value,
    output logic       hit
);
    localparam logic [7:0] MON_OUT  = 8'(MON0_INIT + 1);
    localparam logic [7:0] YEAR_OUT = 8'(YEAR_SINCE_1900 - YEAR_BIAS);

    always_comb begin
        hit   = 1'b1;
        value = BAD_VAL;
        case (index)
            IDX_SEC:   value = 8'(SEC_INIT);
            IDX_MIN:   value = 8'(MIN_INIT);
            IDX_HOUR:  value = 8'(HOUR_INIT);
            IDX_WDAY:  value = 8'(WDAY_INIT);
            IDX_MDAY:  value = 8'(MDAY_INIT);
            IDX_MON:   value = MON_OUT;
            IDX_YEAR:  value = YEAR_OUT;
            IDX_STATA: value = {uip, STATA_LOW};
            IDX_CTLB:  value = CTLB_VAL;
            IDX_CTLC:  value = CTLC_VAL;
            default:   hit   = 1'b0;
        endcase
    end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_regs_pkg::*;
#(
    parameter logic [7:0] INDEX_PORT = 8'h70,
    parameter logic [7:0] DATA_PORT  = 8'h71,
    parameter int TICK_CYCLES = 97656,
    parameter int SEC_INIT   = 0,
    parameter int MIN_INIT   = 0,
    parameter int HOUR_INIT  = 0,
    parameter int WDAY_INIT  = 0,
    parameter int MDAY_INIT  = 1,
    parameter int MON0_INIT  = 0,
    parameter int YEAR_SINCE_1900 = 106
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       bus_err,
    output logic       tick_irq
);
    port_state_t st_d, st_q;
    logic [7:0]  sel_idx;
    logic [7:0]  mux_val;
    logic        mux_hit;

    rtc_reg_mux #(
        .SEC_INIT(SEC_INIT), .MIN_INIT(MIN_INIT), .HOUR_INIT(HOUR_INIT),
        .WDAY_INIT(WDAY_INIT), .MDAY_INIT(MDAY_INIT), .MON0_INIT(MON0_INIT),
        .YEAR_SINCE_1900(YEAR_SINCE_1900)
    ) mux_i (
        .index(st_q.index),
        .uip  (st_q.uip),
        .value(mux_val),
        .hit  (mux_hit)
    );

    rtc_tick_div #(.TICK_CYCLES(TICK_CYCLES)) div_i (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_irq)
    );

    always_comb begin
        st_d = st_q;
        st_d.err = 1'b0;
        if (bus_wr && bus_addr == INDEX_PORT) begin
            st_d.index = bus_wdata;
        end else if (bus_wr && bus_addr == DATA_PORT) begin
            st_d.err = 1'b1;
        end else if (bus_rd && bus_addr == DATA_PORT) begin
            st_d.rdata = mux_val;
            st_d.err   = !mux_hit;
            if (st_q.index == IDX_STATA) st_d.uip = !st_q.uip;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.uip   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_idx   = st_q.index;
    assign bus_rdata = st_q.rdata;
    assign bus_err   = st_q.err;
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk #(
    parameter logic [7:0] INDEX_PORT = 8'h70,
    parameter logic [7:0] DATA_PORT  = 8'h71,
    parameter int TICK_CYCLES = 97656
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic       bus_err,
    input logic       tick_irq,
    input logic [7:0] sel_idx
);
    int   gap_q;
    logic data_rd, stat_rd, other_acc, idx_known;

    assign data_rd   = bus_rd && bus_addr == DATA_PORT;
    assign stat_rd   = data_rd && sel_idx == 8'd10;
    assign other_acc = (bus_rd || bus_wr) && bus_addr != DATA_PORT && bus_addr != INDEX_PORT;
    assign idx_known = sel_idx inside {8'd0, 8'd2, 8'd4, 8'd6, 8'd7, 8'd8,
                                       8'd9, 8'd10, 8'd11, 8'd12};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        gap_q <= 0;
        else if (tick_irq) gap_q <= 1;
        else               gap_q <= gap_q + 1;
    end

    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |=> !tick_irq);
    assert_irq_period_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |-> gap_q == TICK_CYCLES);
    assert_stat_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> bus_rdata[6:0] == 7'h26 && !bus_err);
    assert_uip_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && $past(stat_rd)) |=> bus_rdata[7] != $past(bus_rdata[7]));
    assert_ctlb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && sel_idx == 8'd11) |=> bus_rdata == 8'h46 && !bus_err);
    assert_ctlc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && sel_idx == 8'd12) |=> bus_rdata == 8'h00 && !bus_err);
    assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !idx_known) |=> bus_err && bus_rdata == 8'hFF);
    assert_data_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DATA_PORT) |=> bus_err && $stable(bus_rdata) && $stable(sel_idx));
    assert_other_offset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        other_acc |=> !bus_err && $stable(bus_rdata) && $stable(sel_idx));
    assert_index_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == INDEX_PORT) |=> !bus_err && $stable(bus_rdata));
endmodule

bind rtc_regfile rtc_regfile_chk #(
    .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT), .TICK_CYCLES(TICK_CYCLES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .tick_irq(tick_irq), .sel_idx(sel_idx)
);

// File: tb/rtc_regfile_tb_top.sv
module rtc_regfile_tb_top;
    localparam int N      = 12;
    localparam int SEC    = 37;
    localparam int MIN    = 5;
    localparam int HOUR   = 23;
    localparam int WDAY   = 6;
    localparam int MDAY   = 31;
    localparam int MON0   = 11;
    localparam int YR1900 = 123;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       bus_err;
    logic       tick_irq;

    int checks = 0;
    int fails = 0;
    int ecount = 0;
    logic model_uip = 1'b1;
    logic done = 1'b0;

    always #5 clk = ~clk;

    rtc_regfile #(
        .TICK_CYCLES(N), .SEC_INIT(SEC), .MIN_INIT(MIN), .HOUR_INIT(HOUR),
        .WDAY_INIT(WDAY), .MDAY_INIT(MDAY), .MON0_INIT(MON0),
        .YEAR_SINCE_1900(YR1900)
    ) dut_i (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One-cycle strobe; sampled at the negedge after the capturing posedge.
    task automatic access(input logic wr, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = wr; bus_rd = !wr;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    function automatic int expect_val(input int idx, input logic uip);
        case (idx)
            0:  return SEC;
            2:  return MIN;
            4:  return HOUR;
            6:  return WDAY;
            7:  return MDAY;
            8:  return MON0 + 1;
            9:  return (YR1900 - 52) & 8'hFF;
            10: return {uip, 7'h26};
            11: return 8'h46;
            12: return 8'h00;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic string tag_of(input int idx);
        case (idx)
            0, 2, 4, 6, 7: return "R2";
            8:  return "R3";
            9:  return "R4";
            10: return "R5";
            11: return "R6";
            12: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic read_check(input int idx, input string extra);
        int exp;
        exp = expect_val(idx, model_uip);
        access(1'b0, 8'h71, 8'h00);
        check({tag_of(idx), extra}, bus_rdata, exp);
        check({tag_of(idx), extra, " err"}, bus_err, (exp == 8'hFF) ? 1 : 0);
        if (idx == 10) model_uip = !model_uip;
    endtask

    // R11: tick_irq high exactly after every N-th edge since release.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            ecount++;
            check("R11 irq", tick_irq, (ecount % N == 0) ? 1 : 0);
        end
    end

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 rdata reset", bus_rdata, 0);
        check("R10 err reset", bus_err, 0);
        check("R10 irq reset", tick_irq, 0);
        #1 rst_n = 1'b1;

        // Full sweep of register numbers (R1..R8)
        for (int i = 0; i < 256; i++) begin
            access(1'b1, 8'h70, 8'(i));
            read_check(i, " sweep");
            if (i <= 13) read_check(i, " R1 repeat");
        end

        // R5: back-to-back status reads alternate the flag
        access(1'b1, 8'h70, 8'd10);
        @(negedge clk);
        bus_addr = 8'h71; bus_rd = 1'b1;
        @(negedge clk);
        check("R5 b2b first", bus_rdata, {model_uip, 7'h26});
        model_uip = !model_uip;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R5 b2b second", bus_rdata, {model_uip, 7'h26});
        model_uip = !model_uip;

        // R9: data-port write flags error, changes nothing
        access(1'b1, 8'h70, 8'd0);
        read_check(0, " before R9");
        access(1'b1, 8'h71, 8'h55);
        check("R9 err", bus_err, 1);
        check("R9 rdata held", bus_rdata, SEC);
        @(negedge clk);
        check("R9 err one cycle", bus_err, 0);
        read_check(0, " after R9 index kept");
        access(1'b1, 8'h70, 8'd10);
        read_check(10, " R9 flag kept");

        // R10: read result holds across idle cycles
        repeat (3) @(negedge clk);
        check("R10 hold", bus_rdata, {!model_uip, 7'h26});
        check("R10 err low", bus_err, 0);

        // R12: other offsets ignored
        access(1'b1, 8'h72, 8'd8);
        check("R12 wr err", bus_err, 0);
        check("R12 wr rdata", bus_rdata, {!model_uip, 7'h26});
        access(1'b0, 8'h70, 8'h00);
        check("R12 rd err", bus_err, 0);
        check("R12 rd rdata", bus_rdata, {!model_uip, 7'h26});
        access(1'b1, 8'h00, 8'd9);
        read_check(10, " R12 index kept");

        // R1: new index replaces old
        access(1'b1, 8'h70, 8'd9);
        read_check(9, " R1 reindex");

        repeat (2 * N) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule